// File: doc/BRIEF.md
# Link Test Pattern Checker

This block sits on the receive side of a serial lane and checks received symbols against a fixed repeating pattern. It reports any lane bit errors as a running mismatch count. The expected pattern is an 80-bit buffer made of eight 10-bit chunks. The transmit-side generator reads the same buffer. The checker can compare at one of two points. It can compare raw 10-bit line symbols, taken before the decoder. Or it can compare the decoded byte together with its control flag, taken after the decoder.

After it is started, the checker scans the incoming valid symbols for chunk 0. When it finds one, it declares alignment and then expects chunks 1 through 7 in order, wrapping back to chunk 0. Every valid symbol that differs from the expected chunk adds one to a saturating error counter. The counter can be held at zero on its own, separately from the engine reset. The engine reset clears all of the checker's state. A buffer whose first chunk is a comma is illegal, because alignment on it would be ambiguous. Such a buffer is flagged and blocks alignment.

Top module: `lane_pattern_checker`

## Requirements
- R1: After the synchronous reset `rst`, `err_count` is 0, and `locked`, `overflow` and `cfg_err` are 0.
- R2: While `chk_en` is 0, no symbol is compared: `locked` does not change and `err_count` does not change.
- R3: While `run` is 0, comparison is stopped: alignment state and `err_count` are frozen.
- R4: Before alignment, valid symbols that differ from chunk 0 are ignored. The first valid symbol equal to chunk 0 sets `locked` on the following clock edge. Chunk k is `pat_buf[10k+9:10k]`.
- R5: Once locked, each following valid symbol is compared with chunk 1, 2, …, 7, then chunk 0, and the sequence repeats. Cycles with `sym_vld` low do not advance the sequence.
- R6: With `dom_sel` = 0 (raw domain), all ten bits of `sym` are compared.
- R7: With `dom_sel` = 1 (decoded domain), `sym[7:0]` holds the data byte and `sym[8]` holds the control flag, and both are compared. `sym[9]` and chunk bit 9 are ignored.
- R8: Each mismatching valid symbol while locked raises `err_count` by exactly one. The new value is visible after the next clock edge.
- R9: While `cnt_clr` is 1, `err_count` is held at 0 and `overflow` is cleared. Alignment continues to advance during this time.
- R10: `err_count` is 16 bits wide and stops at 65535. A mismatch that arrives while it is at 65535 sets `overflow`. `overflow` stays set until `cnt_clr`, `eng_rst` or `rst` clears it.
- R11: `cfg_err` rises one cycle after chunk 0 becomes a comma. In the raw domain the commas are 0011111010 and 1100000101. In the decoded domain a comma is any chunk whose bits [7:0] equal 0xBC. While chunk 0 is a comma, `locked` is forced to 0.
- R12: `eng_rst` clears alignment, `err_count` and `overflow` on the next edge. The checker then needs chunk 0 again before it locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Checker enable |
| run | input | 1 | Start (1) / stop (0) comparison |
| eng_rst | input | 1 | Engine reset: clears alignment and counter |
| cnt_clr | input | 1 | Hold error counter at zero |
| dom_sel | input | 1 | 0: raw 10-bit compare, 1: decoded data+flag compare |
| pat_buf | input | 80 | Expected pattern, chunk k at bits [10k+9:10k] |
| sym_vld | input | 1 | Received symbol valid |
| sym | input | 10 | Received symbol (decoded domain: [8] flag, [7:0] data) |
| err_count | output | 16 | Saturating mismatch count |
| locked | output | 1 | Aligned to pattern |
| overflow | output | 1 | Sticky counter saturation flag |
| cfg_err | output | 1 | Chunk 0 is a comma symbol |

## Verification
If the internal chunk index goes wrong, even by a single step, the very next valid symbol is compared with the wrong chunk. `err_count` then starts rising within one cycle, on a stream the bench knows to be error-free. If the lock state goes wrong, either `locked` shows the wrong value directly, or errors are counted, or not counted, from the first symbol after the edge. A bad domain mask shows up the same way, one cycle after a bit-9 or bit-8 flip. Saturation faults are exposed when the bench drives the counter all the way to its limit.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
  localparam logic [9:0] COMMA_RD_NEG = 10'b0011111010;
  localparam logic [9:0] COMMA_RD_POS = 10'b1100000101;
  localparam logic [7:0] COMMA_BYTE   = 8'hBC;

  // True when a chunk may not serve as the alignment chunk.
  function automatic logic chunk_is_comma(input logic [9:0] c, input logic decoded);
    if (decoded) return (c[7:0] == COMMA_BYTE);
    return (c == COMMA_RD_NEG) || (c == COMMA_RD_POS);
  endfunction
endpackage

// File: rtl/pchk_cfg_guard.sv
module pchk_cfg_guard #(
  parameter int SYM_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] chunk0_i,
  input  logic             dom_i,
  output logic             illegal_o,
  output logic             cfg_err_o
);
  import pchk_pkg::*;

  logic [9:0] c10;
  assign c10       = 10'(chunk0_i);
  assign illegal_o = chunk_is_comma(c10, dom_i);

  always_ff @(posedge clk) begin
    if (rst) cfg_err_o <= 1'b0;
    else     cfg_err_o <= illegal_o;
  end

  // R11
  cfg_follow_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> cfg_err_o);
endmodule

// File: rtl/pchk_align.sv
module pchk_align #(
  parameter int SYM_W  = 10,
  parameter int NCHUNK = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    abort_i,
  input  logic                    step_i,
  input  logic                    dom_i,
  input  logic [SYM_W-1:0]        sym_i,
  input  logic [SYM_W*NCHUNK-1:0] pat_i,
  output logic                    locked_o,
  output logic                    mism_o
);
  localparam int IW = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
  localparam logic [IW-1:0] LAST = IW'(NCHUNK - 1);
  localparam logic [SYM_W-1:0] MASK_RAW = '1;
  localparam logic [SYM_W-1:0] MASK_DEC = {1'b0, {(SYM_W-1){1'b1}}};

  logic [SYM_W-1:0] chunk [NCHUNK];
  logic [IW-1:0]    idx_q;
  logic [SYM_W-1:0] mask, expect_sym;
  logic             hit0, hit;

  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign chunk[g] = pat_i[g*SYM_W +: SYM_W];
  end

  assign mask       = dom_i ? MASK_DEC : MASK_RAW;
  assign expect_sym = chunk[idx_q];
  assign hit0       = ((sym_i ^ chunk[0]) & mask) == '0;
  assign hit        = ((sym_i ^ expect_sym) & mask) == '0;
  assign mism_o     = step_i && locked_o && !abort_i && !hit;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      locked_o <= 1'b0;
      idx_q    <= '0;
    end else if (step_i) begin
      if (!locked_o) begin
        if (hit0) begin
          locked_o <= 1'b1;
          idx_q    <= (LAST == '0) ? '0 : IW'(1);
        end
      end else begin
        idx_q <= (idx_q == LAST) ? '0 : idx_q + IW'(1);
      end
    end
  end

  // R11
  abort_no_lock_chk: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> !locked_o);
  // R5
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !abort_i) |=> $stable(idx_q) && $stable(locked_o));
  // R4
  lock_needs_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!locked_o && !step_i) |=> !locked_o);
endmodule

// File: rtl/pchk_err_cnt.sv
module pchk_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (inc_i) begin
      if (cnt_o == MAXV) ovf_o <= 1'b1;
      else               cnt_o <= cnt_o + 1'b1;
    end
  end

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0) && !ovf_o);
  // R10
  ovf_sat_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (cnt_o == MAXV));
  // R8
  inc_one_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i && cnt_o != MAXV) |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/lane_pattern_checker.sv
module lane_pattern_checker #(
  parameter int SYM_W  = 10,
  parameter int NCHUNK = 8,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    chk_en,
  input  logic                    run,
  input  logic                    eng_rst,
  input  logic                    cnt_clr,
  input  logic                    dom_sel,
  input  logic [SYM_W*NCHUNK-1:0] pat_buf,
  input  logic                    sym_vld,
  input  logic [SYM_W-1:0]        sym,
  output logic [CNT_W-1:0]        err_count,
  output logic                    locked,
  output logic                    overflow,
  output logic                    cfg_err
);
  logic illegal, step, mism, eng_clr;

  assign eng_clr = rst || eng_rst;
  assign step    = chk_en && run && sym_vld;

  pchk_cfg_guard #(.SYM_W(SYM_W)) guard_i (
    .clk(clk), .rst(rst), .chunk0_i(pat_buf[SYM_W-1:0]), .dom_i(dom_sel),
    .illegal_o(illegal), .cfg_err_o(cfg_err));

  pchk_align #(.SYM_W(SYM_W), .NCHUNK(NCHUNK)) align_i (
    .clk(clk), .rst(eng_clr), .abort_i(illegal), .step_i(step),
    .dom_i(dom_sel), .sym_i(sym), .pat_i(pat_buf),
    .locked_o(locked), .mism_o(mism));

  pchk_err_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(eng_clr), .clr_i(cnt_clr), .inc_i(mism),
    .cnt_o(err_count), .ovf_o(overflow));

  // R2 R3
  idle_freeze_chk: assert property (@(posedge clk) disable iff (eng_clr)
    (!(chk_en && run) && !cnt_clr && !illegal) |=> $stable(err_count) && $stable(locked));
  // R12
  eng_rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    eng_rst |=> !locked && err_count == '0 && !overflow);
endmodule

// File: tb/lane_pattern_checker_tb_top.sv
`timescale 1ns/1ps
module lane_pattern_checker_tb_top;
  logic clk = 0;
  logic rst = 1, chk_en = 0, run = 0, eng_rst = 0, cnt_clr = 0, dom_sel = 0;
  logic [79:0] pat_buf;
  logic sym_vld = 0;
  logic [9:0] sym = '0;
  logic [15:0] err_count;
  logic locked, overflow, cfg_err;

  int n_chk = 0, n_err = 0;
  string req = "R1";

  // model state
  logic        m_lk = 0, m_ov = 0, m_cfg = 0;
  int          m_ix = 0;
  int unsigned m_cnt = 0;

  always #4 clk = ~clk;

  lane_pattern_checker dut_i (
    .clk(clk), .rst(rst), .chk_en(chk_en), .run(run), .eng_rst(eng_rst),
    .cnt_clr(cnt_clr), .dom_sel(dom_sel), .pat_buf(pat_buf), .sym_vld(sym_vld),
    .sym(sym), .err_count(err_count), .locked(locked), .overflow(overflow),
    .cfg_err(cfg_err));

  function automatic logic [9:0] ck(int k);
    return pat_buf[k*10 +: 10];
  endfunction

  function automatic logic is_bad();
    if (dom_sel) return ck(0)[7:0] == 8'hBC;
    return ck(0) == 10'b0011111010 || ck(0) == 10'b1100000101;
  endfunction

  function automatic logic same(logic [9:0] a, logic [9:0] b);
    return dom_sel ? (a[8:0] == b[8:0]) : (a == b);
  endfunction

  task automatic model_step();
    logic bad;
    bad = is_bad();
    if (rst) m_cfg = 0; else m_cfg = bad;
    if (rst || eng_rst) begin
      m_lk = 0; m_ix = 0; m_cnt = 0; m_ov = 0;
    end else begin
      if (bad) begin
        m_lk = 0; m_ix = 0;
      end else if (chk_en && run && sym_vld) begin
        if (!m_lk) begin
          if (same(sym, ck(0))) begin m_lk = 1; m_ix = 1; end
        end else begin
          if (!same(sym, ck(m_ix)) && !cnt_clr) begin
            if (m_cnt == 65535) m_ov = 1; else m_cnt++;
          end
          m_ix = (m_ix + 1) % 8;
        end
      end
      if (cnt_clr) begin m_cnt = 0; m_ov = 0; end
    end
  endtask

  task automatic cyc(input logic v, input logic [9:0] s);
    @(negedge clk);
    sym_vld = v; sym = s;
    model_step();
    @(posedge clk); #2;
    n_chk++;
    if (err_count != m_cnt[15:0] || locked != m_lk || overflow != m_ov || cfg_err != m_cfg) begin
      n_err++;
      $display("FAIL %s: cnt=%0d lk=%0b ov=%0b cfg=%0b expected cnt=%0d lk=%0b ov=%0b cfg=%0b",
               req, err_count, locked, overflow, cfg_err, m_cnt, m_lk, m_ov, m_cfg);
    end
  endtask

  // sends the correct next symbol, optionally flipping one bit
  task automatic send_exp(input int flip);
    logic [9:0] s;
    s = m_lk ? ck(m_ix) : ck(0);
    if (flip >= 0) s[flip] = ~s[flip];
    cyc(1'b1, s);
  endtask

  task automatic set_pat();
    for (int k = 0; k < 8; k++) pat_buf[k*10 +: 10] = 10'((k * 97 + 'hA3) & 'h3FF);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    set_pat();
    req = "R1";
    repeat (3) cyc(1'b0, '0);
    rst = 0;
    cyc(1'b0, '0);

    chk_en = 1; run = 1; dom_sel = 0;
    req = "R4";
    for (int i = 0; i < 5; i++) cyc(1'b1, 10'h3FF);
    send_exp(-1);
    req = "R5";
    for (int i = 0; i < 20; i++) begin
      send_exp(-1);
      if (i % 3 == 0) cyc(1'b0, 10'h3FF);
    end

    req = "R6";
    for (int p = 0; p < 8; p++)
      for (int b = 0; b < 10; b++) begin
        send_exp(b);
        send_exp(-1);
      end
    req = "R8";
    for (int i = 0; i < 4; i++) send_exp(0);

    req = "R2";
    chk_en = 0;
    for (int i = 0; i < 6; i++) cyc(1'b1, 10'h3FF);
    chk_en = 1;
    req = "R3";
    run = 0;
    for (int i = 0; i < 6; i++) cyc(1'b1, 10'h3FF);
    run = 1;
    send_exp(-1);

    req = "R9";
    cnt_clr = 1;
    for (int i = 0; i < 5; i++) send_exp(3);
    cnt_clr = 0;
    for (int i = 0; i < 5; i++) send_exp(-1);

    req = "R12";
    eng_rst = 1; cyc(1'b1, 10'h3FF); eng_rst = 0;
    for (int i = 0; i < 3; i++) cyc(1'b1, 10'h3FF);
    send_exp(-1); send_exp(-1);

    req = "R7";
    dom_sel = 1;
    eng_rst = 1; cyc(1'b0, '0); eng_rst = 0;
    send_exp(9);
    for (int p = 0; p < 16; p++) send_exp(p % 2 == 0 ? 9 : 8);
    for (int b = 0; b < 9; b++) send_exp(b);

    req = "R11";
    dom_sel = 0;
    pat_buf[9:0] = 10'b0011111010; send_exp(-1); send_exp(-1);
    pat_buf[9:0] = 10'b1100000101; send_exp(-1); send_exp(-1);
    pat_buf[9:0] = 10'h2BC; send_exp(-1); send_exp(-1);
    dom_sel = 1; send_exp(-1); send_exp(-1);
    pat_buf[9:0] = 10'h1BC; send_exp(-1); send_exp(-1);
    dom_sel = 0; send_exp(-1); send_exp(-1);
    set_pat(); send_exp(-1); send_exp(-1);

    req = "R10";
    eng_rst = 1; cyc(1'b0, '0); eng_rst = 0;
    send_exp(-1);
    for (int i = 0; i < 65540; i++) send_exp(1);
    send_exp(-1);
    cnt_clr = 1; send_exp(-1); cnt_clr = 0;
    send_exp(-1);

    req = "R1";
    rst = 1; cyc(1'b0, '0); rst = 0; cyc(1'b0, '0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule